// File: doc/BRIEF.md
# Lockable Configuration Register with Trusted Boot Load

This block holds one 32-bit system configuration word. A two-bit lock code at bits 15:14 decides who may change the word. Code 00 leaves everything open. Code 10 freezes the configuration fields but still lets the lock code be rewritten. Code 11 freezes everything, the lock code included, until the next reset. Four protection flags at bits 13:10 can only be set by software. They clear only on reset.

During a pre-boot window, a stored configuration word can be copied into the register. The copy happens only when the word comes with no failure status and no blank indication. Some fields are never taken from the stored word:

- the lock code,
- the four flags,
- the debug-port enable at bit 3,
- the hot-plug disable at bit 20.

Software uses a plain write port with byte enables. Downstream logic uses the full register value, a one-hot decode of the lock level and a gated trace-output enable.

The lock level is a small state machine. Its states are OPEN (00), RELOCK (10), PERM (11) and RSVD (01). The transitions are:

- OPEN_TO_RELOCK, OPEN_TO_PERM, RELOCK_TO_OPEN and RELOCK_TO_PERM happen on an accepted lock write.
- OPEN_HOLD and RELOCK_HOLD happen when the lock write is rejected or absent.
- PERM_HOLD is the only exit from PERM.
- RSVD_HOLD is the only exit from RSVD. RSVD cannot be entered, because code 01 is never accepted.

Top module: `cfgreg_lockable_top`

## Requirements
- R1: After reset the register reads 0x7960000B, lock_open is 1, and lock_relockable and lock_permanent are 0.
- R2: While the lock code is 00 or 10, a bus write with wr_be[1]=1 loads wr_data[15:14] into the lock code when that value is 00, 10 or 11. A written value of 01 is discarded. The decoded outputs are: lock_open for 00, lock_relockable for 10, lock_permanent for 11.
- R3: Once the lock code is 11, no bus write and no boot load changes it until reset.
- R4: Bits 30:17, 9:7 and 4:1 take bus write data only while the lock code is 00. Under 10 or 11 they keep their value.
- R5: Bits 13:10 are set by writing 1 while the lock code is 00. Writing 0 has no effect, and only reset clears them.
- R6: A boot load happens when boot_valid, preboot_active, !boot_fail and !boot_blank are all true. It copies boot_word into bits 30:21, 19:17, 9:7, 4 and 2:1, whatever the lock code. Otherwise the register is unchanged.
- R7: A boot load never alters bits 15:14, 13:10, 20 or 3.
- R8: When a boot load and a bus write fall in the same cycle, the boot load is applied and the bus write is discarded entirely.
- R9: Bits 31, 16, 6, 5 and 0 always read 0, 0, 0, 0 and 1.
- R10: wr_be[k] gates bits 8k+7 down to 8k of a write. The lock code therefore needs wr_be[1].
- R11: trace_out_en equals register bit 2 AND trace_allow.
- R12: Write permission is judged on the lock code before the write. A single write at code 00 that sets the code to 10 or 11 also updates the open fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write data |
| wr_be | input | 4 | Byte enables |
| boot_valid | input | 1 | Boot-load strobe |
| boot_word | input | 32 | Stored configuration word |
| boot_fail | input | 1 | Boot configuration fail status |
| boot_blank | input | 1 | Stored word blank or erased |
| preboot_active | input | 1 | Pre-boot window open |
| trace_allow | input | 1 | External trace enable |
| cfg_value | output | 32 | Register contents |
| lock_open | output | 1 | Lock code is 00 |
| lock_relockable | output | 1 | Lock code is 10 |
| lock_permanent | output | 1 | Lock code is 11 |
| trace_out_en | output | 1 | Effective trace output enable |

## Verification
The bench sweeps every pairing of a starting lock level (00, 10, 11) with all four written lock codes. This separates correct lock-code transitions from wrong ones and open-field updates from frozen ones, and it catches a check made against the post-write lock code.

All sixteen byte-enable masks are applied with byte-distinct data, which exposes a wrong byte lane. The eight combinations of fail, blank and pre-boot are each tried with and without a bus write in the same cycle. This separates a trusted load from an untrusted one, bus priority from boot priority, and the excluded fields from the loaded ones.

A two-by-two sweep of bit 2 against trace_allow pins the trace gating.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    localparam int          REG_W      = 32;
    localparam int          BYTES      = REG_W / 8;
    localparam logic [31:0] RESET_VAL  = 32'h7960_000B;
    localparam logic [31:0] RW_MASK    = 32'h7FFE_039E; // 30:17, 9:7, 4:1
    localparam logic [31:0] SET_MASK   = 32'h0000_3C00; // 13:10
    localparam logic [31:0] LOCK_MASK  = 32'h0000_C000; // 15:14
    localparam logic [31:0] BOOT_MASK  = 32'h7FEE_0396; // RW minus bits 20, 3
    localparam logic [31:0] RSVD_MASK  = 32'h8001_0061; // 31, 16, 6, 5, 0
    localparam int          LOCK_LSB   = 14;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'b00,
        LK_RSVD   = 2'b01,
        LK_RELOCK = 2'b10,
        LK_PERM   = 2'b11
    } lock_e;
endpackage

// File: rtl/cfgreg_lock_fsm.sv
module cfgreg_lock_fsm
    import cfgreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_wr,
    input  logic [1:0] lock_wdata,
    output lock_e      lock_state,
    output logic       is_open,
    output logic       is_relock,
    output logic       is_perm
);
    lock_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN, LK_RELOCK: begin
                if (lock_wr && (lock_wdata != LK_RSVD))
                    state_d = lock_e'(lock_wdata);
            end
            LK_PERM: state_d = LK_PERM;
            LK_RSVD: state_d = LK_RSVD;
        endcase
    end

    always_comb begin
        lock_state = state_q;
        is_open    = 1'b0;
        is_relock  = 1'b0;
        is_perm    = 1'b0;
        unique case (state_q)
            LK_OPEN:   is_open   = 1'b1;
            LK_RELOCK: is_relock = 1'b1;
            LK_PERM:   is_perm   = 1'b1;
            LK_RSVD:   ;
        endcase
    end
endmodule

// File: rtl/cfgreg_field_bank.sv
module cfgreg_field_bank
    import cfgreg_pkg::*;
#(
    parameter logic [REG_W-1:0] INIT = RESET_VAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [REG_W-1:0] sw_data,
    input  logic [BYTES-1:0] sw_be,
    input  logic             boot_ld,
    input  logic [REG_W-1:0] boot_data,
    output logic [REG_W-1:0] fields
);
    logic [REG_W-1:0] be_bits;
    logic [REG_W-1:0] fields_d;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign be_bits[b*8 +: 8] = {8{sw_be[b]}};
    end

    always_comb begin
        fields_d = fields;
        if (boot_ld) begin
            fields_d = (fields & ~BOOT_MASK) | (boot_data & BOOT_MASK);
        end else if (sw_wr) begin
            fields_d = (fields & ~(RW_MASK & be_bits))
                     | (sw_data & RW_MASK & be_bits)
                     | (sw_data & SET_MASK & be_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fields <= INIT & ~LOCK_MASK;
        else        fields <= fields_d;
    end
endmodule

// File: rtl/cfgreg_lockable_top.sv
module cfgreg_lockable_top
    import cfgreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be,
    input  logic        boot_valid,
    input  logic [31:0] boot_word,
    input  logic        boot_fail,
    input  logic        boot_blank,
    input  logic        preboot_active,
    input  logic        trace_allow,
    output logic [31:0] cfg_value,
    output logic        lock_open,
    output logic        lock_relockable,
    output logic        lock_permanent,
    output logic        trace_out_en
);
    logic        boot_take;
    logic        bus_fire;
    lock_e       lock_state;
    logic [31:0] fields;

    assign boot_take = boot_valid & preboot_active & ~boot_fail & ~boot_blank;
    assign bus_fire  = wr_en & ~boot_take;

    cfgreg_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (bus_fire & wr_be[LOCK_LSB/8]),
        .lock_wdata (wr_data[LOCK_LSB +: 2]),
        .lock_state (lock_state),
        .is_open    (lock_open),
        .is_relock  (lock_relockable),
        .is_perm    (lock_permanent)
    );

    cfgreg_field_bank #(.INIT(RESET_VAL)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (bus_fire & lock_open),
        .sw_data   (wr_data),
        .sw_be     (wr_be),
        .boot_ld   (boot_take),
        .boot_data (boot_word),
        .fields    (fields)
    );

    always_comb begin
        cfg_value = fields;
        cfg_value[LOCK_LSB +: 2] = lock_state;
    end

    assign trace_out_en = cfg_value[2] & trace_allow;
endmodule

// File: rtl/cfgreg_lockable_chk.sv
module cfgreg_lockable_chk
    import cfgreg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        boot_valid,
    input logic        boot_fail,
    input logic        boot_blank,
    input logic        preboot_active,
    input logic        trace_allow,
    input logic [31:0] cfg_value,
    input logic        lock_open,
    input logic        lock_relockable,
    input logic        lock_permanent,
    input logic        trace_out_en
);
    logic trusted;
    assign trusted = boot_valid & preboot_active & ~boot_fail & ~boot_blank;

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_value[15:14] == 2'b11) |=> (cfg_value[15:14] == 2'b11)); // R3

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_value[15:14] != 2'b00) && !trusted) |=>
        ((cfg_value & RW_MASK) == ($past(cfg_value) & RW_MASK))); // R4

    AST_FLAGS_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_value[13:10] & $past(cfg_value[13:10])) == $past(cfg_value[13:10]))); // R5

    AST_UNTRUSTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_valid && (boot_fail || boot_blank) && !wr_en) |=> $stable(cfg_value)); // R6

    AST_RSVD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_value & RSVD_MASK) == (RESET_VAL & RSVD_MASK)); // R9

    AST_LOCK_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_open, lock_relockable, lock_permanent})); // R2

    AST_TRACE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trace_out_en |-> (trace_allow && cfg_value[2])); // R11
endmodule

bind cfgreg_lockable_top cfgreg_lockable_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .boot_valid      (boot_valid),
    .boot_fail       (boot_fail),
    .boot_blank      (boot_blank),
    .preboot_active  (preboot_active),
    .trace_allow     (trace_allow),
    .cfg_value       (cfg_value),
    .lock_open       (lock_open),
    .lock_relockable (lock_relockable),
    .lock_permanent  (lock_permanent),
    .trace_out_en    (trace_out_en)
);

// File: tb/cfgreg_lockable_tb.sv
`timescale 1ns/1ps
module cfgreg_lockable_top_tb_top;
    localparam logic [31:0] RST  = 32'h7960_000B;
    localparam logic [31:0] RW   = 32'h7FFE_039E;
    localparam logic [31:0] SETM = 32'h0000_3C00;
    localparam logic [31:0] BOOT = 32'h7FEE_0396;
    localparam logic [31:0] RSVM = 32'h8001_0061;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        boot_valid = 1'b0;
    logic [31:0] boot_word = '0;
    logic        boot_fail = 1'b0;
    logic        boot_blank = 1'b0;
    logic        preboot_active = 1'b0;
    logic        trace_allow = 1'b1;
    logic [31:0] cfg_value;
    logic        lock_open, lock_relockable, lock_permanent, trace_out_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_v;

    always #5 clk = ~clk;

    cfgreg_lockable_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
        .boot_valid(boot_valid), .boot_word(boot_word), .boot_fail(boot_fail),
        .boot_blank(boot_blank), .preboot_active(preboot_active),
        .trace_allow(trace_allow), .cfg_value(cfg_value), .lock_open(lock_open),
        .lock_relockable(lock_relockable), .lock_permanent(lock_permanent),
        .trace_out_en(trace_out_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, e);
        end
    endtask

    function automatic logic [31:0] m_wr(input logic [31:0] c, input logic [31:0] d,
                                         input logic [3:0] be);
        logic [31:0] bm;
        logic [31:0] n;
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        n = c;
        if (c[15:14] == 2'b00)
            n = (c & ~(RW & bm)) | (d & RW & bm) | (d & SETM & bm);
        if ((c[15:14] == 2'b00 || c[15:14] == 2'b10) && be[1] && d[15:14] != 2'b01)
            n[15:14] = d[15:14];
        return n;
    endfunction

    function automatic logic [2:0] m_dec(input logic [1:0] l);
        return {l == 2'b00, l == 2'b10, l == 2'b11};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        boot_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_v = RST;
    endtask

    task automatic bus_wr(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
        exp_v = m_wr(exp_v, d, be);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset value and decode
        chk("R1", cfg_value, RST);
        chk("R1", {29'd0, lock_open, lock_relockable, lock_permanent}, 32'd4);

        // R10 byte enable sweep at open lock, lock bits kept 00
        for (int be = 0; be < 16; be++) begin
            logic [31:0] d;
            d = {8'(8'h3C ^ (be * 8'h11)), 8'(8'hA5 + be), 8'(8'h0F ^ be), 8'(8'h96 - be)};
            d[15:14] = 2'b00;
            bus_wr(d, 4'(be));
            chk("R10", cfg_value, exp_v);
            chk("R9", cfg_value & RSVM, RST & RSVM);
        end
        // R5 flags cannot be cleared by writing zero
        bus_wr(32'h0000_3C00, 4'hF);
        chk("R5", cfg_value[13:10], 4'hF);
        bus_wr(32'h0000_0000, 4'hF);
        chk("R5", {28'd0, cfg_value[13:10]}, 32'hF);
        do_reset();
        chk("R5", {28'd0, cfg_value[13:10]}, 32'h0);

        // R2 R3 R4 R12 lock sweep
        for (int s = 0; s < 3; s++) begin
            for (int w = 0; w < 4; w++) begin
                logic [1:0] st;
                logic [31:0] d;
                st = (s == 0) ? 2'b00 : (s == 1) ? 2'b10 : 2'b11;
                do_reset();
                bus_wr({16'd0, st, 14'd0}, 4'b0010);
                d = 32'h2A5A_1296 | {16'd0, 2'(w), 14'd0};
                bus_wr(d, 4'hF);
                chk("R2", cfg_value, exp_v);
                chk("R2", {29'd0, lock_open, lock_relockable, lock_permanent},
                    {29'd0, m_dec(exp_v[15:14])});
                if (st == 2'b11) chk("R3", {30'd0, cfg_value[15:14]}, 32'd3);
                if (st != 2'b00) chk("R4", cfg_value & RW, RST & RW & ~32'h0000_0300);
                if (st == 2'b00 && w >= 2) chk("R12", cfg_value & RW, d & RW);
            end
        end

        // R6 R7 R8 boot load sweep
        for (int k = 0; k < 16; k++) begin
            logic f, bl, pre, with_wr, take;
            logic [31:0] bw, wd;
            f = k[0]; bl = k[1]; pre = k[2]; with_wr = k[3];
            take = pre && !f && !bl;
            bw = (k % 2 == 0) ? 32'hFFFF_FFFF : 32'h5555_5555;
            wd = 32'h0000_0000;
            do_reset();
            bus_wr(32'h0000_8000, 4'b0010); // lock 10
            @(negedge clk);
            boot_valid = 1'b1; boot_word = bw; boot_fail = f; boot_blank = bl;
            preboot_active = pre; wr_en = with_wr; wr_data = wd; wr_be = 4'hF;
            @(negedge clk);
            boot_valid = 1'b0; wr_en = 1'b0; preboot_active = 1'b0;
            if (take) exp_v = (exp_v & ~BOOT) | (bw & BOOT);
            else if (with_wr) exp_v = m_wr(exp_v, wd, 4'hF);
            chk(with_wr ? "R8" : "R6", cfg_value, exp_v);
            chk("R7", cfg_value & ~BOOT & ~RSVM, exp_v & ~BOOT & ~RSVM);
        end
        // R3 boot load does not touch permanent lock
        do_reset();
        bus_wr(32'h0000_C000, 4'b0010);
        @(negedge clk);
        boot_valid = 1'b1; boot_word = 32'h0; boot_fail = 1'b0; boot_blank = 1'b0;
        preboot_active = 1'b1;
        @(negedge clk);
        boot_valid = 1'b0; preboot_active = 1'b0;
        chk("R3", {30'd0, cfg_value[15:14]}, 32'd3);
        chk("R7", {31'd0, cfg_value[3]}, 32'd1);

        // R11 trace gating sweep
        for (int t = 0; t < 4; t++) begin
            do_reset();
            bus_wr({29'd0, t[0], 2'b00}, 4'b0001);
            trace_allow = t[1];
            @(negedge clk);
            chk("R11", {31'd0, trace_out_en}, {31'd0, t[0] & t[1]});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule